// File: doc/BRIEF.md
# UART Transmit Byte Queue with Fill Watermark

This block sits between a UART's write-data register and its serializer. Each write strobe offers one byte. The byte is appended to a circular byte store. A downstream transmitter takes bytes in arrival order through a valid/ready handshake, and only while the transmit enable is set. The block reports its fill count along with full and empty flags. It also keeps a watermark state with hysteresis against a software-chosen limit, and it produces a one-cycle pulse each time the queue runs dry.

A flush input discards the whole contents in one cycle. When the queue is full, further writes are dropped without notice. The serializer, the receive side and any interrupt masking are outside this block.

Top module: `txq_top`

## Requirements
- R1: After reset the level is 0, `empty_o`=1, `full_o`=0, `wm_o`=0, `empty_evt_o`=0 and `out_valid_o`=0.
- R2: Accepted bytes leave on `out_data_o` in write order. A byte is consumed in every cycle where `out_valid_o` and `out_ready_i` are both high.
- R3: A write made while the level equals the depth (32) is discarded, even if a byte drains in the same cycle. The level then does not rise.
- R4: `full_o` is 1 exactly when the level is 32. It clears in the cycle after any byte drains.
- R5: `empty_o` clears after an accepted write. It sets when the level returns to 0.
- R6: `empty_evt_o` pulses high for one cycle when the level goes from non-zero to zero, by draining or by flushing.
- R7: The 3-bit `wm_thresh_i` value T selects a limit of 2^T, capped at 32. So T=0 gives 1, T=2 gives 4, and T=5, 6 or 7 give 32.
- R8: `wm_o` sets after a cycle with a write request in which the resulting level is at or above the limit.
- R9: `wm_o` clears after a drain that leaves the level below the limit. Otherwise it holds, so changing the threshold alone does not change it.
- R10: `flush_i` empties the queue and clears `wm_o` at the next edge. A write or drain in that same cycle has no effect, and `out_valid_o` is held low during the flush.
- R11: `out_valid_o` is 1 only when `tx_enable_i`=1 and the queue holds data. With the enable low, the contents are kept.
- R12: `level_o` reports the number of stored bytes, from 0 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe of the data register |
| wr_data_i | input | 8 | Byte to append |
| tx_enable_i | input | 1 | Transmit enable from control |
| wm_thresh_i | input | 3 | Watermark threshold field |
| flush_i | input | 1 | Flush request (queue reset bit) |
| out_valid_o | output | 1 | Byte available to the serializer |
| out_data_o | output | 8 | Oldest stored byte |
| out_ready_i | input | 1 | Serializer takes the byte |
| level_o | output | 6 | Current fill level |
| full_o | output | 1 | Queue full flag |
| empty_o | output | 1 | Queue empty flag |
| wm_o | output | 1 | Watermark state |
| empty_evt_o | output | 1 | One-cycle pulse when the queue runs dry |

## Verification
The assertions check the following on every cycle:
- the level stays bounded;
- the full flag agrees with the level;
- a write made while full is dropped;
- the output is gated by the enable;
- the flush takes effect;
- a rise of the watermark or a fall of the empty flag is always traced back to a write request.

Only the scenarios can show that byte order is kept across wrap-around, and that the limit decoding is right for each threshold value. The same holds for the hysteresis when the threshold is changed without traffic, and for the behaviour of simultaneous write and drain at the full boundary.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Map the threshold field to a fill limit: a power of two, capped at the depth.
  function automatic int wm_limit(input int thr, input int depth);
    int lim;
    lim = 1 << thr;
    if (lim > depth) lim = depth;
    return lim;
  endfunction

  // Level after one cycle of traffic.
  function automatic int next_level(input int lvl, input bit flush,
                                    input bit push, input bit pop);
    if (flush) return 0;
    return lvl + int'(push) - int'(pop);
  endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr] <= push_data;
  end

  assign head_data = mem[rptr];
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_req,
  input  logic          push,
  input  logic          pop,
  input  logic [LW-1:0] limit,
  output logic [LW-1:0] level,
  output logic [LW-1:0] level_nxt,
  output logic          full,
  output logic          empty,
  output logic          wm,
  output logic          empty_evt
);
  import txq_pkg::*;

  logic wm_nxt;

  assign level_nxt = LW'(next_level(int'(level), flush, push, pop));

  always_comb begin
    wm_nxt = wm;
    if (flush)                           wm_nxt = 1'b0;
    else if (wr_req && level_nxt >= limit) wm_nxt = 1'b1;
    else if (pop && level_nxt < limit)     wm_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level     <= '0;
      full      <= 1'b0;
      empty     <= 1'b1;
      wm        <= 1'b0;
      empty_evt <= 1'b0;
    end else begin
      level     <= level_nxt;
      full      <= (level_nxt == LW'(DEPTH));
      empty     <= (level_nxt == '0);
      wm        <= wm_nxt;
      empty_evt <= (level != '0) && (level_nxt == '0);
    end
  end
endmodule

// File: rtl/txq_top.sv
module txq_top #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int TW    = 3,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          tx_enable_i,
  input  logic [TW-1:0] wm_thresh_i,
  input  logic          flush_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  input  logic          out_ready_i,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          wm_o,
  output logic          empty_evt_o
);
  import txq_pkg::*;

  // Named internal events, visible to the bound checker.
  logic          push_ok;
  logic          pop_ok;
  logic [LW-1:0] limit;
  logic [LW-1:0] level_nxt;

  assign limit       = LW'(wm_limit(int'(wm_thresh_i), DEPTH));
  assign push_ok     = wr_en_i && !flush_i && (level_o != LW'(DEPTH));
  assign out_valid_o = tx_enable_i && !empty_o && !flush_i;
  assign pop_ok      = out_valid_o && out_ready_i;

  txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_i),
    .push      (push_ok),
    .push_data (wr_data_i),
    .pop       (pop_ok),
    .head_data (out_data_o)
  );

  txq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_i),
    .wr_req    (wr_en_i),
    .push      (push_ok),
    .pop       (pop_ok),
    .limit     (limit),
    .level     (level_o),
    .level_nxt (level_nxt),
    .full      (full_o),
    .empty     (empty_o),
    .wm        (wm_o),
    .empty_evt (empty_evt_o)
  );
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en_i,
  input logic          flush_i,
  input logic          tx_enable_i,
  input logic          pop_ok,
  input logic          out_valid_o,
  input logic [LW-1:0] level_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          wm_o,
  input logic          empty_evt_o
);
  p_level_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LW'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && full_o && !flush_i && !pop_ok) |=> $stable(level_o));

  p_full_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> (level_o == LW'(DEPTH)));

  p_empty_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty_o) |-> $past(wr_en_i));

  p_dry_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt_o |-> (empty_o && $past(level_o) != '0));

  p_wm_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wm_o) |-> $past(wr_en_i));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (level_o == '0 && !wm_o));

  p_valid_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (tx_enable_i && level_o != '0));
endmodule

bind txq_top txq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en_i     (wr_en_i),
  .flush_i     (flush_i),
  .tx_enable_i (tx_enable_i),
  .pop_ok      (pop_ok),
  .out_valid_o (out_valid_o),
  .level_o     (level_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .wm_o        (wm_o),
  .empty_evt_o (empty_evt_o)
);

// File: tb/sim_txq_top.sv
module sim_txq_top;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       en = 1'b0;
  logic [2:0] thr = '0;
  logic       flush = 1'b0;
  logic       rdy = 1'b0;
  logic       valid, full, empty, wm, evt;
  logic [7:0] odata;
  logic [5:0] level;

  int errors = 0;
  int checks = 0;
  byte q[$];
  int m_lvl = 0;
  bit m_wm = 0;
  int cycles = 0;
  byte seed = 8'h11;

  always #4 clk = ~clk;   // 125 MHz

  txq_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_enable_i(en), .wm_thresh_i(thr), .flush_i(flush),
    .out_valid_o(valid), .out_data_o(odata), .out_ready_i(rdy),
    .level_o(level), .full_o(full), .empty_o(empty), .wm_o(wm),
    .empty_evt_o(evt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Threshold decoding, written as a table (R7).
  function automatic int lim_of(input logic [2:0] t);
    case (t)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 16;
      default: return 32;
    endcase
  endfunction

  // Monitor: a handshake seen at the falling edge completes at the next rise (R2).
  always @(negedge clk) begin
    if (rst_n && valid && rdy) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2: actual=%0d expected=none (queue empty)", odata);
      end else begin
        byte e;
        e = q.pop_front();
        if (odata != e) begin
          errors++;
          $display("FAIL R2: actual=%0d expected=%0d", odata, e);
        end
      end
    end
  end

  // One cycle of stimulus followed by a model update and flag checks.
  task automatic step(input bit w, input byte d, input bit r, input bit f);
    bit acc, drn, was_nz;
    int nxt;
    wr_en = w; wr_data = d; rdy = r; flush = f;
    drn = en && (m_lvl != 0) && r && !f;
    acc = w && !f && (m_lvl < DEPTH);
    @(posedge clk); #1;
    was_nz = (m_lvl != 0);
    nxt = f ? 0 : m_lvl + int'(acc) - int'(drn);
    if (f) m_wm = 0;
    else if (w && nxt >= lim_of(thr)) m_wm = 1;
    else if (drn && nxt < lim_of(thr)) m_wm = 0;
    if (f) q.delete();
    if (acc) q.push_back(d);
    m_lvl = nxt;
    chk("R12", int'(level), m_lvl);
    chk("R4",  int'(full), int'(m_lvl == DEPTH));
    chk("R5",  int'(empty), int'(m_lvl == 0));
    chk("R8/R9", int'(wm), int'(m_wm));
    chk("R6",  int'(evt), int'(was_nz && m_lvl == 0));
    wr_en = 0; rdy = 0; flush = 0;
  endtask

  task automatic wr(input int n);
    for (int i = 0; i < n; i++) begin
      seed = seed * 8'd5 + 8'd3;
      step(1, seed, 0, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", int'(level), 0); chk("R1", int'(empty), 1);
    chk("R1", int'(full), 0);  chk("R1", int'(wm), 0);
    chk("R1", int'(evt), 0);   chk("R1", int'(valid), 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R7/R8/R11: limit 4, transmit disabled, data held
    thr = 3'd2; en = 0;
    wr(5);
    chk("R8", int'(wm), 1);
    step(0, 0, 1, 0);
    chk("R11", int'(valid), 0);
    chk("R11", int'(level), 5);

    // R9: raising the threshold alone leaves the watermark set
    thr = 3'd7;
    step(0, 0, 0, 0);
    chk("R9", int'(wm), 1);
    thr = 3'd2;

    // R2/R9: drain with enable; the watermark clears below 4
    en = 1;
    step(0, 0, 1, 0);
    chk("R9", int'(wm), 1);
    step(0, 0, 1, 0);
    chk("R9", int'(wm), 0);
    step(0, 0, 1, 0); step(0, 0, 1, 0); step(0, 0, 1, 0);
    chk("R6", int'(evt), 1);
    step(0, 0, 0, 0);
    chk("R6", int'(evt), 0);

    // R3/R4: overfill with transmit off, then simultaneous write and drain at full
    en = 0; thr = 3'd5;
    wr(34);
    chk("R3", int'(level), 32);
    chk("R4", int'(full), 1);
    en = 1;
    step(1, 8'hAA, 1, 0);     // write dropped, one byte drains
    chk("R3", int'(level), 31);
    chk("R4", int'(full), 0);
    // simultaneous write and drain below full: level stays
    step(1, 8'h5C, 1, 0);
    chk("R2", int'(level), 31);
    // drain everything, wrapping the pointers
    for (int i = 0; i < 31; i++) step(0, 0, 1, 0);
    chk("R5", int'(empty), 1);
    chk("R2", q.size(), 0);

    // R7: threshold 0 gives limit 1
    thr = 3'd0;
    wr(1);
    chk("R7", int'(wm), 1);

    // R10: flush with a write in the same cycle
    wr(6);
    step(1, 8'h77, 1, 1);
    chk("R10", int'(level), 0);
    chk("R10", int'(wm), 0);
    chk("R6", int'(evt), 1);
    // post-flush traffic is clean
    thr = 3'd1;
    wr(3);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0);
    chk("R2", q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=finish", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule